// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Pin Overrides

An eight-pin bidirectional port that sits between the pad ring and the on-chip peripherals. Software owns two registers per port: a direction register (1 = drive the pin) and a port register that holds the output value for driven pins and the pull-up request for undriven pins. Pad input values are brought into the clock domain through a multi-stage synchroniser. The synchronised values are then returned to software and routed to the peripherals.

Each pin has a set of override pairs, each an enable and a value, for pull-up, direction, output value and digital input enable. The peripheral mode signals drive these pairs, and the pairs take priority over the software registers. The fixed pin map is as follows. Bit 0 carries the divided clock out. Bit 1 carries timer 1 compare A. Bit 2 carries SPI slave select and timer 1 compare B. Bit 3 carries SPI master-out, the timer 2 compare A output and USART transmit. Bit 4 carries SPI master-in and USART receive. Bit 5 carries the SPI clock. Bits 6 and 7 can be claimed as oscillator input and oscillator output. A pin-change mask together with a group enable keeps a pin's digital input alive while inputs are otherwise gated off.

Top module: `pin_mux_port`

## Requirements
- R1: While reset is asserted and after it, the direction and port registers hold 0. With no override active, every pin then has pad_oe = 0 and pad_pu = 0.
- R2: A bit with no active override has pad_oe = its direction bit and pad_out = its port bit. Its pad_pu = 1 only when its direction bit is 0, its port bit is 1 and pud is 0. No pin ever has pad_oe and pad_pu both at 1.
- R3: With spi_en = 1 and spi_master = 0 (slave), bits 5, 2 and 3 are forced to input. With spi_en = 1 and spi_master = 1, bit 4 is forced to input. The pull-up of a forced-input bit is its port bit AND NOT pud.
- R4: In master mode, bit 5 outputs spi_sck_o. In slave mode, bit 4 outputs spi_miso_o. The direction of these two bits still comes from the direction register.
- R5: With urx_en = 1, bit 4 is forced to input, with the R3 pull-up rule. With utx_en = 1, bit 3 is forced to output with its pull-up off. This holds even when SPI slave mode is also active.
- R6: When any of SPI master, t2a_en or utx_en is active, bit 3 outputs the OR of spi_mosi_o (master only), t2a (when t2a_en) and utx_d (when utx_en).
- R7: The timer compare enables override only the output value. t1a_en drives t1a on bit 1 and t1b_en drives t1b on bit 2. The pin's pad_oe stays equal to its direction bit.
- R8: With clko_en = 1, bit 0 has pad_oe = 1, pad_out = clk_div and pad_pu = 0, whatever the registers hold. This also holds while rst_n is low.
- R9: osc_claim_lo claims bit 6 and osc_claim_hi claims bit 7. A claimed bit has pad_oe = 0, pad_pu = 0 and a disabled digital input. Its rd_dir, rd_port and rd_pin bits read 0.
- R10: A bit with pc_mask = 1 while pc_en = 1 keeps its digital input enabled, even when dig_in_off = 1. An oscillator claim still wins over this.
- R11: An unforced digital input is enabled when dig_in_off = 0. din is the synchronised pad value AND the input enable, and rd_pin equals din.
- R12: A pad_in change shows on din and rd_pin SYNC_STAGES clock edges later, and not before.
- R13: A write strobe (wr_dir_en or wr_port_en) loads wr_data at the next clock edge. rd_dir and rd_port show the new value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir_en | input | 1 | Load direction register from wr_data |
| wr_port_en | input | 1 | Load port register from wr_data |
| wr_data | input | 8 | Register write data |
| rd_dir | output | 8 | Direction register readback (claimed bits read 0) |
| rd_port | output | 8 | Port register readback (claimed bits read 0) |
| rd_pin | output | 8 | Synchronised, input-enabled pin values |
| pud | input | 1 | Global pull-up disable |
| dig_in_off | input | 1 | Disable digital inputs that no override keeps on |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode (slave when 0) |
| spi_sck_o | input | 1 | SPI clock out (master) |
| spi_miso_o | input | 1 | SPI slave data out |
| spi_mosi_o | input | 1 | SPI master data out |
| urx_en | input | 1 | USART receiver enabled |
| utx_en | input | 1 | USART transmitter enabled |
| utx_d | input | 1 | USART transmit data |
| t2a_en | input | 1 | Timer 2 compare A output enabled |
| t2a | input | 1 | Timer 2 compare A value |
| t1a_en | input | 1 | Timer 1 compare A output enabled |
| t1a | input | 1 | Timer 1 compare A value |
| t1b_en | input | 1 | Timer 1 compare B output enabled |
| t1b | input | 1 | Timer 1 compare B value |
| clko_en | input | 1 | Drive divided clock on bit 0 |
| clk_div | input | 1 | Divided system clock |
| osc_claim_lo | input | 1 | Bit 6 claimed by oscillator |
| osc_claim_hi | input | 1 | Bit 7 claimed by oscillator |
| pc_en | input | 1 | Pin-change group enable |
| pc_mask | input | 8 | Per-bit pin-change mask |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| din | output | 8 | Synchronised digital inputs to the peripherals |

## Verification
The assertions take the peripheral mode inputs as levels that are valid at each clock edge, and they accept any combination of them, including SPI slave mode together with the USART transmitter. Only the clock-out check is combinational, so it also covers the reset phase. The stimulus draws every mode bit and data bit freely from $urandom with a fixed seed. It holds pad_in steady for two edges before each comparison, so that the synchroniser has settled when the outputs are sampled. Directed cases pin down conflicts, claims and latency.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
   // Override pairs for one pin. puv = 1 means "pull-up follows port AND NOT pud".
   typedef struct packed {
      logic pue;
      logic puv;
      logic dde;
      logic ddv;
      logic pve;
      logic pvv;
      logic die;
      logic div;
   } pmx_ovr_t;

   localparam pmx_ovr_t PMX_OVR_NONE = '0;
endpackage

// File: rtl/pmx_sync.sv
module pmx_sync #(
   parameter int WIDTH       = 8,
   parameter int STAGES      = 2,
   parameter bit RESET_FLOPS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (RESET_FLOPS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir_en,
   input  logic             wr_port_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] port_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         port_q <= '0;
      end else begin
         if (wr_dir_en)  dir_q  <= wr_data;
         if (wr_port_en) port_q <= wr_data;
      end
   end
endmodule

// File: rtl/pmx_override_map.sv
module pmx_override_map
   import pmx_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic                 spi_en,
   input  logic                 spi_master,
   input  logic                 spi_sck_o,
   input  logic                 spi_miso_o,
   input  logic                 spi_mosi_o,
   input  logic                 urx_en,
   input  logic                 utx_en,
   input  logic                 utx_d,
   input  logic                 t2a_en,
   input  logic                 t2a,
   input  logic                 t1a_en,
   input  logic                 t1a,
   input  logic                 t1b_en,
   input  logic                 t1b,
   input  logic                 clko_en,
   input  logic                 clk_div,
   input  logic                 osc_claim_lo,
   input  logic                 osc_claim_hi,
   input  logic                 pc_en,
   input  logic [WIDTH-1:0]     pc_mask,
   output pmx_ovr_t [WIDTH-1:0] ovr
);
   localparam int B_CLKO = 0;
   localparam int B_T1A  = 1;
   localparam int B_SEL  = 2;
   localparam int B_MO   = 3;
   localparam int B_MI   = 4;
   localparam int B_SCK  = 5;
   localparam int B_OSCI = 6;
   localparam int B_OSCO = 7;

   logic slave, master;
   assign slave  = spi_en & ~spi_master;
   assign master = spi_en &  spi_master;

   always_comb begin
      ovr = {WIDTH{PMX_OVR_NONE}};

      // pin-change keeps the input alive
      for (int i = 0; i < WIDTH; i++) begin
         if (pc_en && pc_mask[i]) begin
            ovr[i].die = 1'b1;
            ovr[i].div = 1'b1;
         end
      end

      // bit 0: divided clock out
      if (clko_en) begin
         ovr[B_CLKO].dde = 1'b1;  ovr[B_CLKO].ddv = 1'b1;
         ovr[B_CLKO].pve = 1'b1;  ovr[B_CLKO].pvv = clk_div;
         ovr[B_CLKO].pue = 1'b1;  ovr[B_CLKO].puv = 1'b0;
      end

      // bit 1: timer 1 compare A (value only)
      if (t1a_en) begin
         ovr[B_T1A].pve = 1'b1;  ovr[B_T1A].pvv = t1a;
      end

      // bit 2: slave select / timer 1 compare B
      if (slave) begin
         ovr[B_SEL].dde = 1'b1;  ovr[B_SEL].ddv = 1'b0;
         ovr[B_SEL].pue = 1'b1;  ovr[B_SEL].puv = 1'b1;
      end
      if (t1b_en) begin
         ovr[B_SEL].pve = 1'b1;  ovr[B_SEL].pvv = t1b;
      end

      // bit 3: master out / timer 2 compare A / USART transmit
      if (slave) begin
         ovr[B_MO].dde = 1'b1;  ovr[B_MO].ddv = 1'b0;
         ovr[B_MO].pue = 1'b1;  ovr[B_MO].puv = 1'b1;
      end
      if (utx_en) begin
         ovr[B_MO].dde = 1'b1;  ovr[B_MO].ddv = 1'b1;
         ovr[B_MO].pue = 1'b1;  ovr[B_MO].puv = 1'b0;
      end
      if (master || t2a_en || utx_en) begin
         ovr[B_MO].pve = 1'b1;
         ovr[B_MO].pvv = (master & spi_mosi_o) | (t2a_en & t2a) | (utx_en & utx_d);
      end

      // bit 4: master in / USART receive
      if (master || urx_en) begin
         ovr[B_MI].dde = 1'b1;  ovr[B_MI].ddv = 1'b0;
         ovr[B_MI].pue = 1'b1;  ovr[B_MI].puv = 1'b1;
      end
      if (slave) begin
         ovr[B_MI].pve = 1'b1;  ovr[B_MI].pvv = spi_miso_o;
      end

      // bit 5: SPI clock
      if (slave) begin
         ovr[B_SCK].dde = 1'b1;  ovr[B_SCK].ddv = 1'b0;
         ovr[B_SCK].pue = 1'b1;  ovr[B_SCK].puv = 1'b1;
      end
      if (master) begin
         ovr[B_SCK].pve = 1'b1;  ovr[B_SCK].pvv = spi_sck_o;
      end

      // bits 6/7: oscillator claim disconnects the pin entirely
      if (osc_claim_lo) begin
         ovr[B_OSCI] = '{pue: 1'b1, puv: 1'b0, dde: 1'b1, ddv: 1'b0,
                         pve: 1'b0, pvv: 1'b0, die: 1'b1, div: 1'b0};
      end
      if (osc_claim_hi) begin
         ovr[B_OSCO] = '{pue: 1'b1, puv: 1'b0, dde: 1'b1, ddv: 1'b0,
                         pve: 1'b0, pvv: 1'b0, die: 1'b1, div: 1'b0};
      end
   end
endmodule

// File: rtl/pmx_pin_cell.sv
module pmx_pin_cell
   import pmx_pkg::*;
(
   input  pmx_ovr_t ovr,
   input  logic     dir,
   input  logic     port,
   input  logic     pud,
   input  logic     dig_in_off,
   input  logic     sync_in,
   output logic     oe,
   output logic     out,
   output logic     pu,
   output logic     din
);
   logic ie;
   logic pu_req;

   assign pu_req = port & ~pud;
   assign oe     = ovr.dde ? ovr.ddv : dir;
   assign out    = ovr.pve ? ovr.pvv : port;
   assign pu     = ovr.pue ? (ovr.puv & pu_req) : (~dir & pu_req);
   assign ie     = ovr.die ? ovr.div : ~dig_in_off;
   assign din    = sync_in & ie;
endmodule

// File: rtl/pin_mux_port.sv
module pin_mux_port
   import pmx_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SYNC_RESET  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir_en,
   input  logic             wr_port_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_dir,
   output logic [WIDTH-1:0] rd_port,
   output logic [WIDTH-1:0] rd_pin,
   input  logic             pud,
   input  logic             dig_in_off,
   input  logic             spi_en,
   input  logic             spi_master,
   input  logic             spi_sck_o,
   input  logic             spi_miso_o,
   input  logic             spi_mosi_o,
   input  logic             urx_en,
   input  logic             utx_en,
   input  logic             utx_d,
   input  logic             t2a_en,
   input  logic             t2a,
   input  logic             t1a_en,
   input  logic             t1a,
   input  logic             t1b_en,
   input  logic             t1b,
   input  logic             clko_en,
   input  logic             clk_div,
   input  logic             osc_claim_lo,
   input  logic             osc_claim_hi,
   input  logic             pc_en,
   input  logic [WIDTH-1:0] pc_mask,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu,
   output logic [WIDTH-1:0] din
);
   localparam int BIT_OSC_LO = WIDTH - 2;
   localparam int BIT_OSC_HI = WIDTH - 1;

   generate
      if (WIDTH != 8) begin : g_bad_width
         $error("pin_mux_port: the pin map needs WIDTH == 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pin_mux_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0]     dir_q, port_q, sync_q, claim;
   pmx_ovr_t [WIDTH-1:0] ovr;

   pmx_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_dir_en(wr_dir_en), .wr_port_en(wr_port_en),
      .wr_data(wr_data), .dir_q(dir_q), .port_q(port_q)
   );

   pmx_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RESET_FLOPS(SYNC_RESET)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
   );

   pmx_override_map #(.WIDTH(WIDTH)) u_map (
      .spi_en(spi_en), .spi_master(spi_master), .spi_sck_o(spi_sck_o),
      .spi_miso_o(spi_miso_o), .spi_mosi_o(spi_mosi_o),
      .urx_en(urx_en), .utx_en(utx_en), .utx_d(utx_d),
      .t2a_en(t2a_en), .t2a(t2a), .t1a_en(t1a_en), .t1a(t1a),
      .t1b_en(t1b_en), .t1b(t1b), .clko_en(clko_en), .clk_div(clk_div),
      .osc_claim_lo(osc_claim_lo), .osc_claim_hi(osc_claim_hi),
      .pc_en(pc_en), .pc_mask(pc_mask), .ovr(ovr)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         pmx_pin_cell u_cell (
            .ovr(ovr[i]), .dir(dir_q[i]), .port(port_q[i]), .pud(pud),
            .dig_in_off(dig_in_off), .sync_in(sync_q[i]),
            .oe(pad_oe[i]), .out(pad_out[i]), .pu(pad_pu[i]), .din(din[i])
         );
      end
   endgenerate

   always_comb begin
      claim             = '0;
      claim[BIT_OSC_LO] = osc_claim_lo;
      claim[BIT_OSC_HI] = osc_claim_hi;
   end

   assign rd_dir  = dir_q  & ~claim;
   assign rd_port = port_q & ~claim;
   assign rd_pin  = din;

   // ---------------- assertions ----------------
   always_comb begin
      if (clko_en) begin
         p_clkout_r8: assert (pad_oe[0] && (pad_out[0] == clk_div) && !pad_pu[0])
            else $error("clock-out bit not driving divided clock");
      end
   end

   p_drive_no_pullup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pu) == '0)
      else $error("pin driven with pull-up on");

   p_slave_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_en && !spi_master) |-> (!pad_oe[5] && !pad_oe[2] && (utx_en || !pad_oe[3])))
      else $error("SPI slave pin not forced to input");

   p_forced_pullup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_en && !spi_master) |-> (pad_pu[5] == (rd_port[5] && !pud)))
      else $error("forced-input pull-up rule broken");

   p_tx_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
      utx_en |-> (pad_oe[3] && !pad_pu[3]))
      else $error("transmit bit not driven");

   p_claim_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
      osc_claim_hi |-> (!rd_dir[BIT_OSC_HI] && !rd_port[BIT_OSC_HI] &&
                        !rd_pin[BIT_OSC_HI] && !pad_oe[BIT_OSC_HI] && !pad_pu[BIT_OSC_HI]))
      else $error("claimed pin still visible");
endmodule

// File: tb/tb_pin_mux_port.sv
module tb_pin_mux_port;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n;
   logic wr_dir_en, wr_port_en;
   logic [7:0] wr_data;
   logic [7:0] rd_dir, rd_port, rd_pin;
   logic pud, dig_in_off;
   logic spi_en, spi_master, spi_sck_o, spi_miso_o, spi_mosi_o;
   logic urx_en, utx_en, utx_d;
   logic t2a_en, t2a, t1a_en, t1a, t1b_en, t1b;
   logic clko_en, clk_div, osc_claim_lo, osc_claim_hi, pc_en;
   logic [7:0] pc_mask, pad_in, pad_out, pad_oe, pad_pu, din;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m_dir, m_port, m_sync;
   int unsigned seed_v;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_mux_port dut (
      .clk(clk), .rst_n(rst_n), .wr_dir_en(wr_dir_en), .wr_port_en(wr_port_en),
      .wr_data(wr_data), .rd_dir(rd_dir), .rd_port(rd_port), .rd_pin(rd_pin),
      .pud(pud), .dig_in_off(dig_in_off), .spi_en(spi_en), .spi_master(spi_master),
      .spi_sck_o(spi_sck_o), .spi_miso_o(spi_miso_o), .spi_mosi_o(spi_mosi_o),
      .urx_en(urx_en), .utx_en(utx_en), .utx_d(utx_d), .t2a_en(t2a_en), .t2a(t2a),
      .t1a_en(t1a_en), .t1a(t1a), .t1b_en(t1b_en), .t1b(t1b), .clko_en(clko_en),
      .clk_div(clk_div), .osc_claim_lo(osc_claim_lo), .osc_claim_hi(osc_claim_hi),
      .pc_en(pc_en), .pc_mask(pc_mask), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pu(pad_pu), .din(din)
   );

   task automatic chk(input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Expected outputs from the requirement text.
   task automatic expect_vals(output logic [7:0] e_oe, output logic [7:0] e_out,
                              output logic [7:0] e_pu, output logic [7:0] e_din,
                              output logic [7:0] e_rdir, output logic [7:0] e_rport);
      logic slave, mast;
      logic [7:0] fpu, ie, cl;
      slave = spi_en & ~spi_master;
      mast  = spi_en &  spi_master;
      fpu   = m_port & {8{~pud}};
      e_oe  = m_dir;
      e_out = m_port;
      e_pu  = ~m_dir & fpu;
      ie    = {8{~dig_in_off}} | (pc_mask & {8{pc_en}});       // R10, R11
      if (slave) begin                                        // R3, R4
         e_oe[5] = 1'b0; e_pu[5] = fpu[5];
         e_oe[3] = 1'b0; e_pu[3] = fpu[3];
         e_oe[2] = 1'b0; e_pu[2] = fpu[2];
         e_out[4] = spi_miso_o;
      end
      if (mast) begin
         e_out[5] = spi_sck_o;
         e_oe[4] = 1'b0; e_pu[4] = fpu[4];
      end
      if (urx_en) begin e_oe[4] = 1'b0; e_pu[4] = fpu[4]; end  // R5
      if (utx_en) begin e_oe[3] = 1'b1; e_pu[3] = 1'b0; end
      if (mast || t2a_en || utx_en)                           // R6
         e_out[3] = (mast & spi_mosi_o) | (t2a_en & t2a) | (utx_en & utx_d);
      if (t1b_en) e_out[2] = t1b;                             // R7
      if (t1a_en) e_out[1] = t1a;
      if (clko_en) begin e_oe[0] = 1'b1; e_out[0] = clk_div; e_pu[0] = 1'b0; end // R8
      cl = {osc_claim_hi, osc_claim_lo, 6'b0};                // R9
      e_oe  = e_oe & ~cl;
      e_pu  = e_pu & ~cl;
      ie    = ie & ~cl;
      e_din = m_sync & ie;
      e_rdir  = m_dir & ~cl;
      e_rport = m_port & ~cl;
   endtask

   task automatic check_all(input string tag);
      logic [7:0] e_oe, e_out, e_pu, e_din, e_rdir, e_rport;
      expect_vals(e_oe, e_out, e_pu, e_din, e_rdir, e_rport);
      chk(tag, "pad_oe", pad_oe, e_oe);
      chk(tag, "pad_out", pad_out, e_out);
      chk(tag, "pad_pu", pad_pu, e_pu);
      chk(tag, "din", din, e_din);
      chk(tag, "rd_pin", rd_pin, e_din);
      chk(tag, "rd_dir", rd_dir, e_rdir);
      chk(tag, "rd_port", rd_port, e_rport);
   endtask

   task automatic clear_periph();
      pud = 0; dig_in_off = 0; spi_en = 0; spi_master = 0; spi_sck_o = 0;
      spi_miso_o = 0; spi_mosi_o = 0; urx_en = 0; utx_en = 0; utx_d = 0;
      t2a_en = 0; t2a = 0; t1a_en = 0; t1a = 0; t1b_en = 0; t1b = 0;
      clko_en = 0; clk_div = 0; osc_claim_lo = 0; osc_claim_hi = 0;
      pc_en = 0; pc_mask = 0;
   endtask

   // Called at a negedge: writes land at the next posedge.
   task automatic write_regs(input logic to_dir, input logic to_port, input logic [7:0] v);
      wr_dir_en = to_dir; wr_port_en = to_port; wr_data = v;
      @(posedge clk);
      @(negedge clk);
      wr_dir_en = 0; wr_port_en = 0;
      if (to_dir)  m_dir  = v;
      if (to_port) m_port = v;
   endtask

   // Let the synchroniser absorb pad_in, then sample at a negedge.
   task automatic settle();
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      m_sync = pad_in;
   endtask

   initial begin
      seed_v = $urandom(32'h5eed);
      rst_n = 0; wr_dir_en = 0; wr_port_en = 0; wr_data = 0; pad_in = 0;
      m_dir = 0; m_port = 0; m_sync = 0;
      clear_periph();

      // R8: clock out while reset is held
      @(negedge clk);
      clko_en = 1; clk_div = 1;
      #1;
      chk("R8", "pad_out during reset", pad_out & 8'h01, 8'h01);
      chk("R8", "pad_oe during reset", pad_oe & 8'h01, 8'h01);
      @(negedge clk);
      clk_div = 0;
      #1;
      chk("R8", "pad_out low during reset", pad_out & 8'h01, 8'h00);
      clko_en = 0;

      // R1: reset state
      @(negedge clk);
      check_all("R1");
      rst_n = 1;
      settle();
      check_all("R1");

      // R13: write timing
      wr_dir_en = 1; wr_data = 8'hA5;
      #1;
      chk("R13", "rd_dir before edge", rd_dir, 8'h00);
      @(posedge clk);
      @(negedge clk);
      wr_dir_en = 0; m_dir = 8'hA5;
      chk("R13", "rd_dir after edge", rd_dir, 8'hA5);
      write_regs(0, 1, 8'h3C);
      chk("R13", "rd_port after edge", rd_port, 8'h3C);

      // R2: plain behaviour, pull-up disable
      write_regs(1, 0, 8'h0F);
      write_regs(0, 1, 8'h33);
      check_all("R2");
      pud = 1;
      #1;
      check_all("R2");
      pud = 0;

      // R12: synchroniser latency
      pad_in = 8'h3C;
      @(posedge clk);
      @(negedge clk);
      chk("R12", "rd_pin after one edge", rd_pin, 8'h00);
      @(posedge clk);
      @(negedge clk);
      chk("R12", "rd_pin after two edges", rd_pin, 8'h3C);
      m_sync = 8'h3C;

      // R3, R4: SPI slave, then master
      write_regs(1, 1, 8'hFF);
      spi_en = 1; spi_miso_o = 1;
      settle();
      check_all("R3");
      chk("R3", "slave forced inputs", pad_oe & 8'h2C, 8'h00);
      write_regs(1, 0, 8'h00);
      check_all("R4");
      spi_master = 1; spi_sck_o = 1; spi_mosi_o = 0;
      #1;
      check_all("R4");
      chk("R4", "sck value", pad_out & 8'h20, 8'h20);

      // R5: transmit beats slave input, receive forces input
      spi_master = 0; utx_en = 1; utx_d = 1; urx_en = 1;
      write_regs(1, 1, 8'h10);
      check_all("R5");
      chk("R5", "tx driven", pad_oe & 8'h18, 8'h08);

      // R6: OR on bit 3
      clear_periph();
      spi_en = 1; spi_master = 1; spi_mosi_o = 0; t2a_en = 1; t2a = 1;
      write_regs(1, 1, 8'h08);
      check_all("R6");
      chk("R6", "bit3 value", pad_out & 8'h08, 8'h08);
      t2a = 0;
      #1;
      chk("R6", "bit3 value low", pad_out & 8'h08, 8'h00);

      // R7: timer compare only on the value
      clear_periph();
      t1a_en = 1; t1a = 1; t1b_en = 1; t1b = 1;
      write_regs(1, 1, 8'h00);
      check_all("R7");
      chk("R7", "oe stays off", pad_oe & 8'h06, 8'h00);
      write_regs(1, 0, 8'h06);
      check_all("R7");

      // R9: oscillator claims
      clear_periph();
      write_regs(1, 1, 8'hFF);
      pad_in = 8'hFF; osc_claim_lo = 1; osc_claim_hi = 1; pc_en = 1; pc_mask = 8'hC0;
      settle();
      check_all("R9");
      chk("R9", "rd_dir claimed", rd_dir, 8'h3F);

      // R10, R11: pin-change keeps input alive while gated
      clear_periph();
      dig_in_off = 1; pc_en = 1; pc_mask = 8'h81;
      #1;
      check_all("R10");
      chk("R11", "din gated", din, 8'h81);

      // random mix
      for (int it = 0; it < 300; it++) begin
         logic do_dir, do_port;
         logic [7:0] v;
         pud = $urandom() % 2; dig_in_off = $urandom() % 2;
         spi_en = $urandom() % 2; spi_master = $urandom() % 2;
         spi_sck_o = $urandom() % 2; spi_miso_o = $urandom() % 2; spi_mosi_o = $urandom() % 2;
         urx_en = $urandom() % 2; utx_en = $urandom() % 2; utx_d = $urandom() % 2;
         t2a_en = $urandom() % 2; t2a = $urandom() % 2;
         t1a_en = $urandom() % 2; t1a = $urandom() % 2;
         t1b_en = $urandom() % 2; t1b = $urandom() % 2;
         clko_en = $urandom() % 2; clk_div = $urandom() % 2;
         osc_claim_lo = ($urandom() % 4) == 0; osc_claim_hi = ($urandom() % 4) == 0;
         pc_en = $urandom() % 2; pc_mask = 8'($urandom());
         pad_in = 8'($urandom());
         do_dir = ($urandom() % 3) == 0; do_port = ($urandom() % 3) == 0;
         v = 8'($urandom());
         wr_dir_en = do_dir; wr_port_en = do_port; wr_data = v;
         @(posedge clk);
         @(negedge clk);
         wr_dir_en = 0; wr_port_en = 0;
         if (do_dir)  m_dir  = v;
         if (do_port) m_port = v;
         @(posedge clk);
         @(negedge clk);
         m_sync = pad_in;
         check_all("R2 R3 R5 R6 R9 R10 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule